// File: doc/BRIEF.md
# UART Receive Data and Error Status Unit

This block sits behind a UART receive shift register. Each time the deserializer completes a frame, it presents the word together with three per-frame indications: noise seen, framing fault and parity mismatch. The unit moves the word into a receive data register and sets a data-full flag. It keeps four sticky error flags (overrun, noise, framing, parity) and drives one level-sensitive interrupt request. That request is gated by a receive enable and a parity enable.

A host reads two addresses. Address 0 returns the status byte and address 1 returns the data register. Reading the data register empties it. The error flags are cleared only by a status read followed by a data read, with no new flag set in between. A frame that completes while the data register is still full is dropped. The held word is kept, and only the overrun flag records the event.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status byte reads 0x00, the data-full flag is 0 and `irq` is 0.
- R2: A completed frame that finds data-full at 0 is written into the data register and sets data-full (status bit 5). Its noise, framing and parity indications set status bits 2, 1 and 0, and these bits stay set until they are cleared. A data read in the same cycle as the frame counts as having emptied the register first, so the frame is loaded.
- R3: A completed frame that finds data-full at 1, with no data read in the same cycle, sets overrun (status bit 3). It leaves the data register and data-full unchanged, and the frame is lost.
- R4: A frame that causes an overrun changes no flag other than overrun. Its framing, noise and parity indications are ignored.
- R5: A read of address 1 clears data-full.
- R6: A read of address 0 arms the clear. The next read of address 1 then clears all four error flags, provided it arrives before any new flag-setting event. A flag-setting event is an overrun, or a loaded frame carrying any error indication, and such an event cancels the arming. Flags set in the same cycle as a clear still end up set.
- R7: A read of address 1 that is not armed leaves the four error flags unchanged.
- R8: `irq` = (`rx_ie` AND (data-full OR overrun)) OR (`par_ie` AND parity). The noise and framing flags never drive it.
- R9: `rd_data` shows the status byte when `rd_addr`=0, with bits 7, 6 and 4 reading 0. It shows the data register when `rd_addr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A frame completed this cycle |
| frm_data | input | DW | Completed frame word |
| frm_noise | input | 1 | Noise seen on this frame |
| frm_ferr | input | 1 | Framing fault or break on this frame |
| frm_perr | input | 1 | Parity mismatch on this frame |
| rx_ie | input | 1 | Enable for data-full and overrun interrupts |
| par_ie | input | 1 | Enable for the parity interrupt |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 1 | 0 = status, 1 = data |
| rd_data | output | RW | Read data |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is the interplay between the two-step clear and hardware events. One variant is a status read followed by an overrun before the data read, where the arming must be lost. Another is a frame arriving in the very cycle of a data read. Directed sequences set up each of these orderings explicitly. Random traffic then uses heavy frame and read rates, so that arming, overruns and same-cycle collisions occur hundreds of times against the bench's model.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_noise,
  input  logic          frm_ferr,
  input  logic          frm_perr,
  input  logic          rx_ie,
  input  logic          par_ie,
  input  logic          rd_en,
  input  logic          rd_addr,
  output logic [(DW > 8 ? DW : 8)-1:0] rd_data,
  output logic          irq
);
  localparam int RW = (DW > 8) ? DW : 8;

  logic [DW-1:0] dreg;
  logic full, ovr, nf, fe, pe, armed;

  wire st_rd    = rd_en & ~rd_addr;
  wire dt_rd    = rd_en & rd_addr;
  wire full_eff = full & ~dt_rd;
  wire load     = frm_valid & ~full_eff;
  wire over     = frm_valid & full_eff;
  wire clr      = dt_rd & armed;
  wire set_any  = over | (load & (frm_noise | frm_ferr | frm_perr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg  <= '0;
      full  <= 1'b0;
      ovr   <= 1'b0;
      nf    <= 1'b0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (load) dreg <= frm_data;
      full <= load | full_eff;
      ovr  <= (ovr & ~clr) | over;
      nf   <= (nf  & ~clr) | (load & frm_noise);
      fe   <= (fe  & ~clr) | (load & frm_ferr);
      pe   <= (pe  & ~clr) | (load & frm_perr);
      if (set_any)    armed <= 1'b0;
      else if (st_rd) armed <= 1'b1;
      else if (dt_rd) armed <= 1'b0;
    end
  end

  wire [7:0] status = {2'b00, full, 1'b0, ovr, nf, fe, pe};

  assign rd_data = rd_addr ? RW'(dreg) : RW'(status);
  assign irq     = (rx_ie & (full | ovr)) | (par_ie & pe);

  // R3
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && full && !(rd_en && rd_addr)) |=> ($stable(dreg) && ovr && full));

  // R4
  overrun_no_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && full && !(rd_en && rd_addr) && !fe && !(rd_en && !rd_addr && armed)) |=> !fe);

  // R7
  unarmed_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr && !armed && ovr) |=> ovr);

  // R6
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr && armed && !frm_valid) |=> !(ovr || nf || fe || pe));

  // R5
  data_read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr && !frm_valid) |=> !full);

  // R8
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !par_ie) |-> !irq);
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, frm_noise = 0, frm_ferr = 0, frm_perr = 0;
  logic [7:0] frm_data = 0;
  logic rx_ie = 0, par_ie = 0, rd_en = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, fails = 0;

  logic [7:0] m_d;
  logic m_full, m_ovr, m_nf, m_fe, m_pe, m_arm;

  always #10 clk = ~clk;

  uart_rx_status #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_noise(frm_noise), .frm_ferr(frm_ferr), .frm_perr(frm_perr),
    .rx_ie(rx_ie), .par_ie(par_ie), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  function automatic logic [7:0] m_status();
    return {2'b00, m_full, 1'b0, m_ovr, m_nf, m_fe, m_pe};
  endfunction

  function automatic logic m_irq();
    return (rx_ie & (m_full | m_ovr)) | (par_ie & m_pe);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_d = 0; m_full = 0; m_ovr = 0; m_nf = 0; m_fe = 0; m_pe = 0; m_arm = 0;
  endtask

  task automatic m_step();
    logic dt, st, fe_, ld, ov, clr, sa;
    dt = rd_en & rd_addr; st = rd_en & ~rd_addr;
    fe_ = m_full & ~dt;
    ld = frm_valid & ~fe_; ov = frm_valid & fe_;
    clr = dt & m_arm;
    sa = ov | (ld & (frm_noise | frm_ferr | frm_perr));
    if (ld) m_d = frm_data;
    m_full = ld | fe_;
    m_ovr = (m_ovr & ~clr) | ov;
    m_nf  = (m_nf & ~clr) | (ld & frm_noise);
    m_fe  = (m_fe & ~clr) | (ld & frm_ferr);
    m_pe  = (m_pe & ~clr) | (ld & frm_perr);
    if (sa) m_arm = 0; else if (st) m_arm = 1; else if (dt) m_arm = 0;
  endtask

  task automatic step(logic v, logic [7:0] d, logic n, logic f, logic p, logic re, logic ra);
    frm_valid = v; frm_data = d; frm_noise = n; frm_ferr = f; frm_perr = p;
    rd_en = re; rd_addr = ra;
    #1;
    check(ra ? "R9 data" : "R9 status", rd_data, ra ? m_d : m_status());
    check("R8 irq", {7'd0, irq}, {7'd0, m_irq()});
    @(posedge clk);
    m_step();
    @(negedge clk);
    frm_valid = 0; rd_en = 0;
  endtask

  task automatic peek(logic ra, output logic [7:0] v);
    rd_en = 0; rd_addr = ra; #1; v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(0, v); check("R1 status", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rx_ie = 1;
    step(1, 8'hA5, 1, 0, 0, 0, 0);
    peek(0, v); check("R2 status", v, 8'h24);
    peek(1, v); check("R2 data", v, 8'hA5);
    step(1, 8'h3C, 0, 1, 1, 0, 0);
    peek(1, v); check("R3 data kept", v, 8'hA5);
    peek(0, v); check("R3 status", v, 8'h2C);
    check("R4 fe/pe clear", v & 8'h03, 8'h00);
    step(0, 0, 0, 0, 0, 1, 1);
    peek(0, v); check("R5 full cleared", v & 8'h20, 8'h00);
    check("R7 flags kept", v, 8'h0C);
    check("R8 irq on ovr", {7'd0, irq}, 8'h01);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    peek(0, v); check("R6 cleared", v, 8'h00);
    rx_ie = 0; par_ie = 1;
    step(1, 8'h11, 0, 0, 1, 0, 0);
    peek(0, v); check("R2 parity", v, 8'h21);
    check("R8 parity irq", {7'd0, irq}, 8'h01);
    par_ie = 0; #1;
    check("R8 masked", {7'd0, irq}, 8'h00);
    step(1, 8'h77, 0, 0, 0, 1, 1);
    peek(1, v); check("R2 same-cycle load", v, 8'h77);
    peek(0, v); check("R2 same-cycle status", v, 8'h21);
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 8'h99, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    peek(0, v); check("R6 arm lost", v, 8'h09);
    rx_ie = 0; par_ie = 0;
    step(1, 8'h42, 1, 1, 0, 0, 0);
    check("R8 noise/framing no irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      rx_ie = 1'($urandom); par_ie = 1'($urandom);
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule